// File: doc/BRIEF.md
# Dual Seconds Counter Core

This block keeps two free-standing seconds counts that share one once-per-second tick. The first count advances on every tick, whatever the state of the main supply. The second count measures operating time: it advances only on ticks where the supply-valid input is high, and it holds its value while the supply is reported invalid. The tick, the supply state and the session signal are already synchronous digital inputs. The serial access logic that sits in front of the block supplies the requests.

Software-visible access happens in sessions. A snapshot request copies the selected count into a holding register, and the serial side shifts data out of that register. A tick that lands during the transfer cannot tear the value. A jam-load request replaces the selected count with a full 32-bit word in one cycle. Clear requests are only recorded when they arrive. The selected count goes to zero when the session-active input falls, and one falling edge can clear both counts.

Top module: `dual_seconds_core`

## Requirements
- R1: An asynchronous active-low reset sets both counts and the holding register to zero.
- R2: The continuous count increases by one on every clock where `tick_i` is high, regardless of `supply_ok_i`.
- R3: The operating-time count increases by one only on clocks where both `tick_i` and `supply_ok_i` are high, and otherwise keeps its value.
- R4: When `snap_req_i` is high, the holding register takes the selected count's value from before that clock's update. Without a request, the holding register keeps its value.
- R5: When `load_req_i` is high, all bits of `load_data_i` replace the selected count on that clock. The other count is not affected.
- R6: A clear request does not change a count while the session is open. The pending clear zeroes the count on the clock where `sess_i` is first seen low after being high.
- R7: Clear requests for both counts that are pending in the same session zero both counts at that session's end.
- R8: On each count, a clear has priority over a load, and a load has priority over an increment. A tick on the same clock as a clear or load is discarded for that count.
- R9: Each count wraps from all ones to zero with no flag.
- R10: Select value 0 addresses the continuous count and select value 1 addresses the operating-time count, for both snapshot and load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse once per second |
| supply_ok_i | input | 1 | Main supply reported valid |
| sess_i | input | 1 | Access session open; falling edge applies pending clears |
| snap_req_i | input | 1 | Copy the selected count into the holding register |
| snap_sel_i | input | 1 | Snapshot select: 0 continuous, 1 operating time |
| load_req_i | input | 1 | Jam-load the selected count |
| load_sel_i | input | 1 | Load select: 0 continuous, 1 operating time |
| load_data_i | input | W | Value to load |
| clr_cont_req_i | input | 1 | Request clear of the continuous count at session end |
| clr_op_req_i | input | 1 | Request clear of the operating-time count at session end |
| snap_o | output | W | Holding register contents |

## Verification
The bench builds the block with its default width of 32. At that width, natural ticking can never reach wrap-around. The all-ones corner is reached by jam-loading each count with all ones and then applying one tick. A behavioural model snapshots both counts and is compared with the holding register on every clock. The model also covers ticks that coincide with snapshots, loads and session-end clears, so the priority rules are checked directly.

// File: rtl/dual_seconds_core.sv
module dual_seconds_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         supply_ok_i,
  input  logic         sess_i,
  input  logic         snap_req_i,
  input  logic         snap_sel_i,
  input  logic         load_req_i,
  input  logic         load_sel_i,
  input  logic [W-1:0] load_data_i,
  input  logic         clr_cont_req_i,
  input  logic         clr_op_req_i,
  output logic [W-1:0] snap_o
);

  logic [W-1:0] cont_q, op_q, snap_q;
  logic         sess_q, pend_c, pend_o;

  wire sess_end = sess_q & ~sess_i;
  wire clr_c    = sess_end & (pend_c | clr_cont_req_i);
  wire clr_o    = sess_end & (pend_o | clr_op_req_i);
  wire ld_c     = load_req_i & ~load_sel_i;
  wire ld_o     = load_req_i & load_sel_i;

  assign snap_o = snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cont_q <= '0;
    else if (clr_c)  cont_q <= '0;
    else if (ld_c)   cont_q <= load_data_i;
    else if (tick_i) cont_q <= cont_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     op_q <= '0;
    else if (clr_o)                 op_q <= '0;
    else if (ld_o)                  op_q <= load_data_i;
    else if (tick_i && supply_ok_i) op_q <= op_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          snap_q <= '0;
    else if (snap_req_i) snap_q <= snap_sel_i ? op_q : cont_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q <= 1'b0;
      pend_c <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      sess_q <= sess_i;
      if (sess_end)            pend_c <= 1'b0;
      else if (clr_cont_req_i) pend_c <= 1'b1;
      if (sess_end)            pend_o <= 1'b0;
      else if (clr_op_req_i)   pend_o <= 1'b1;
    end
  end

endmodule

module dual_seconds_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_i,
  input logic         supply_ok_i,
  input logic         sess_i,
  input logic         snap_req_i,
  input logic         snap_sel_i,
  input logic         load_req_i,
  input logic         load_sel_i,
  input logic [W-1:0] load_data_i,
  input logic [W-1:0] cont_q,
  input logic [W-1:0] op_q,
  input logic [W-1:0] snap_o
);

  logic sess_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sess_d <= 1'b0;
    else        sess_d <= sess_i;

  wire fall_w = sess_d & ~sess_i;

  // R2
  cont_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !fall_w && !(load_req_i && !load_sel_i) |=> cont_q == W'($past(cont_q) + 1'b1));

  // R3
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i && !fall_w && !(load_req_i && load_sel_i) |=> $stable(op_q));

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req_i |=> $stable(snap_o));

  // R4
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req_i && !snap_sel_i |=> snap_o == $past(cont_q));

  // R5
  cont_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_i && !load_sel_i && !fall_w |=> cont_q == $past(load_data_i));

  // R6
  no_early_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_w && !tick_i && !(load_req_i && !load_sel_i) |=> $stable(cont_q));

endmodule

bind dual_seconds_core dual_seconds_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .supply_ok_i(supply_ok_i),
  .sess_i(sess_i), .snap_req_i(snap_req_i), .snap_sel_i(snap_sel_i),
  .load_req_i(load_req_i), .load_sel_i(load_sel_i), .load_data_i(load_data_i),
  .cont_q(cont_q), .op_q(op_q), .snap_o(snap_o)
);

// File: tb/test_dual_seconds_core.sv
module test_dual_seconds_core;
  localparam int CLK_P = 10;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 0, supply_ok_i = 0, sess_i = 0;
  logic snap_req_i = 0, snap_sel_i = 0, load_req_i = 0, load_sel_i = 0;
  logic [W-1:0] load_data_i = '0;
  logic clr_cont_req_i = 0, clr_op_req_i = 0;
  logic [W-1:0] snap_o;

  dual_seconds_core #(.W(W)) i_dual_seconds_core (.*);

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "R1";

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [W-1:0] m_cont, m_op, m_snap;
  bit m_sess, m_pc, m_po;
  always @(posedge clk or negedge rst_n) begin
    bit e;
    if (!rst_n) begin
      m_cont = 0; m_op = 0; m_snap = 0; m_sess = 0; m_pc = 0; m_po = 0;
    end else begin
      e = m_sess && !sess_i;
      if (snap_req_i) m_snap = snap_sel_i ? m_op : m_cont;
      if (e && (m_pc || clr_cont_req_i))   m_cont = 0;
      else if (load_req_i && !load_sel_i)  m_cont = load_data_i;
      else if (tick_i)                     m_cont = m_cont + 1;
      if (e && (m_po || clr_op_req_i))     m_op = 0;
      else if (load_req_i && load_sel_i)   m_op = load_data_i;
      else if (tick_i && supply_ok_i)      m_op = m_op + 1;
      if (e) begin m_pc = 0; m_po = 0; end
      else begin
        if (clr_cont_req_i) m_pc = 1;
        if (clr_op_req_i)   m_po = 1;
      end
      m_sess = sess_i;
    end
  end

  always @(negedge clk) if (rst_n && !done) chk(phase, snap_o, m_snap);

  task automatic read_cnt(bit sel);
    snap_req_i = 1; snap_sel_i = sel;
    @(negedge clk);
    snap_req_i = 0;
  endtask

  task automatic load_cnt(bit sel, logic [W-1:0] d);
    load_req_i = 1; load_sel_i = sel; load_data_i = d;
    @(negedge clk);
    load_req_i = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", snap_o, '0);
    rst_n = 1;

    phase = "R2";
    supply_ok_i = 0; tick_i = 1;
    repeat (5) @(negedge clk);
    tick_i = 0;
    read_cnt(0); chk("R2 cont no supply", snap_o, 32'd5);
    phase = "R3";
    read_cnt(1); chk("R3 op held", snap_o, 32'd0);
    supply_ok_i = 1; tick_i = 1;
    repeat (3) @(negedge clk);
    tick_i = 0;
    read_cnt(0); chk("R2 cont", snap_o, 32'd8);
    read_cnt(1); chk("R3 op counts", snap_o, 32'd3);
    repeat (2) @(negedge clk);
    read_cnt(1); chk("R3 no tick", snap_o, 32'd3);

    phase = "R4";
    tick_i = 1; read_cnt(0); tick_i = 0;
    chk("R4 pre-tick value", snap_o, 32'd8);
    read_cnt(0); chk("R4 after tick", snap_o, 32'd9);
    repeat (3) @(negedge clk);
    chk("R4 held", snap_o, 32'd9);
    phase = "R10";
    read_cnt(1); chk("R10 sel 1", snap_o, 32'd4);

    phase = "R5";
    load_cnt(0, 32'hA5A5_1234);
    read_cnt(0); chk("R5 loaded", snap_o, 32'hA5A5_1234);
    read_cnt(1); chk("R5 other kept", snap_o, 32'd4);

    phase = "R8";
    tick_i = 1; load_cnt(1, 32'd100); tick_i = 0;
    read_cnt(1); chk("R8 load beats tick", snap_o, 32'd100);
    read_cnt(0); chk("R8 other ticked", snap_o, 32'hA5A5_1235);

    phase = "R9";
    load_cnt(0, '1);
    tick_i = 1; @(negedge clk); tick_i = 0;
    read_cnt(0); chk("R9 cont wrap", snap_o, 32'd0);
    load_cnt(1, '1);
    tick_i = 1; @(negedge clk); tick_i = 0;
    read_cnt(1); chk("R9 op wrap", snap_o, 32'd0);

    phase = "R6";
    sess_i = 1; @(negedge clk);
    clr_cont_req_i = 1; @(negedge clk); clr_cont_req_i = 0;
    tick_i = 1; repeat (2) @(negedge clk); tick_i = 0;
    read_cnt(0); chk("R6 deferred", snap_o, 32'd3);
    sess_i = 0; tick_i = 1; @(negedge clk); tick_i = 0;
    read_cnt(0); chk("R6 R8 cleared at end", snap_o, 32'd0);
    read_cnt(1); chk("R6 other kept", snap_o, 32'd3);

    phase = "R7";
    sess_i = 1; @(negedge clk);
    clr_cont_req_i = 1; clr_op_req_i = 1; @(negedge clk);
    clr_cont_req_i = 0; clr_op_req_i = 0;
    tick_i = 1; @(negedge clk); tick_i = 0;
    sess_i = 0; @(negedge clk);
    read_cnt(0); chk("R7 cont cleared", snap_o, 32'd0);
    read_cnt(1); chk("R7 op cleared", snap_o, 32'd0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule